// File: doc/BRIEF.md
# Memory-Mapped I2C Master Register Model

This block models the software-visible side of a byte-wide I2C master controller. It sits on a simple synchronous register bus. The bus has an address, write data, a write strobe, a read strobe and combinational read data. Behind that bus sit six byte registers: own slave address, clock divider, input-filter sample rate, control, status and data. No SCL or SDA pins are driven. Data-register traffic only advances a two-step sequencer, which alternates between an address step and a payload step.

Every data-register access that starts a transfer arms a fixed-latency completion counter. The latency is the product of two parameters, `PRE_DIV` and `POST_DIV`. When the counter runs out, the block sets the transfer-complete flag in the status register. If interrupts are allowed, it also sets the interrupt-pending flag, which drives the interrupt output. A data-register read during the payload step is the exception: it completes at once and never flags an interrupt. Software clears the flags by writing the status register.

Top module: `i2cs_regblk`

## Requirements
- R1: Registers sit at byte offsets 0x00 (slave address, 8 bits), 0x04 (divider), 0x05 (filter rate), 0x08 (control), 0x0C (status) and 0x10 (data). After reset every register reads 0x00 and `irq` is low.
- R2: Writes to the divider (0x04) and the filter rate (0x05) store only bits 5:0, and reads return that stored value with bits 7:6 zero. The slave address register stores and returns all 8 bits.
- R3: While control bit 7 (enable) is 0, reads and writes of the data register start no timer, change no phase and set no status flag.
- R4: The sequencer goes back to the address step when a control write takes bit 7 from 0 to 1, and when a control write changes bit 4. A control write that changes neither bit leaves the step unchanged.
- R5: With the block enabled, a data write in the address step moves to the payload step and starts the completion timer. Bits 7:1 of that write are the 7-bit target address and bit 0 has no effect. A data write in the payload step returns to the address step and starts the timer.
- R6: With the block enabled, a data read in the address step moves to the payload step and starts the timer. A data read in the payload step returns to the address step and sets status bit 7 on that same clock edge. That read leaves status bit 1 unchanged.
- R7: The timer expires exactly PRE_DIV*POST_DIV clocks after the edge that started it (32768 by default). On expiry it sets status bit 7 (transfer complete). If control bit 6 (interrupt enable) is 1, it also sets status bit 1 (interrupt pending).
- R8: Starting the timer while it is already running restarts the full count, so the earlier expiry never happens.
- R9: A write to the status register replaces its whole content with the written byte.
- R10: `irq` is high exactly when status bit 1 and control bit 6 are both 1.
- R11: Reads of the data register always return 0x00.
- R12: Reset cancels a running timer and puts the sequencer in the address step.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| bus_addr | input | 5 | Register byte offset |
| bus_wdata | input | 8 | Write data |
| bus_we | input | 1 | Write strobe, one access per asserted cycle |
| bus_re | input | 1 | Read strobe, the access takes effect at the clock edge |
| bus_rdata | output | 8 | Read data for `bus_addr`, combinational |
| irq | output | 1 | Interrupt level |

## Verification
The sequencer step has no port of its own. A wrong step shows up on the first data read that follows: a payload-step read sets the complete flag on the next edge, while an address-step read leaves status at zero until the timer runs out. A miscounting or non-restarting timer shows up as the complete flag and `irq` rising one or more cycles off the expected edge. The bench therefore probes status on the cycle before the expected edge and on the edge itself. A bad enable or bit-4 edge detector leaves the step wrong, and the next probing read exposes it within one cycle.

// File: rtl/i2cs_pkg.sv
// Package: shared register offsets, bit positions and the sequencer step type
// for the I2C register model. Assumes byte offsets fit in REG_AW bits.
package i2cs_pkg;
    localparam int REG_AW  = 5;
    localparam int BYTE_W  = 8;
    localparam int RATE_W  = 6;

    localparam logic [REG_AW-1:0] OFS_SADR = 5'h00;
    localparam logic [REG_AW-1:0] OFS_FDIV = 5'h04;
    localparam logic [REG_AW-1:0] OFS_FILT = 5'h05;
    localparam logic [REG_AW-1:0] OFS_CTRL = 5'h08;
    localparam logic [REG_AW-1:0] OFS_STAT = 5'h0C;
    localparam logic [REG_AW-1:0] OFS_DATA = 5'h10;

    localparam int CTL_EN    = 7;
    localparam int CTL_IE    = 6;
    localparam int CTL_PHRST = 4;
    localparam int STS_DONE  = 7;
    localparam int STS_PEND  = 1;

    typedef enum logic {
        STEP_ADDR = 1'b0,
        STEP_DATA = 1'b1
    } step_e;
endpackage

// File: rtl/i2cs_cfg_regs.sv
// Module: configuration registers (slave address, divider, filter rate,
// control). Also flags a sequencer restart on a control write that raises
// enable or flips bit 4. Assumes at most one bus write per cycle.
module i2cs_cfg_regs
    import i2cs_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [REG_AW-1:0] addr,
    input  logic [BYTE_W-1:0] wdata,
    input  logic              we,
    output logic [BYTE_W-1:0] sadr,
    output logic [RATE_W-1:0] fdiv,
    output logic [RATE_W-1:0] filt,
    output logic [BYTE_W-1:0] ctrl,
    output logic              step_clear
);
    logic ctrl_wr;
    assign ctrl_wr = we && (addr == OFS_CTRL);

    // Restart request: enable goes 0->1 or bit 4 changes on a control write.
    always_comb begin
        step_clear = ctrl_wr &&
                     ((!ctrl[CTL_EN] && wdata[CTL_EN]) ||
                      (ctrl[CTL_PHRST] != wdata[CTL_PHRST]));
    end

    // Register storage; the rate fields keep their low RATE_W bits only.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sadr <= '0;
            fdiv <= '0;
            filt <= '0;
            ctrl <= '0;
        end else if (we) begin
            case (addr)
                OFS_SADR: sadr <= wdata;
                OFS_FDIV: fdiv <= wdata[RATE_W-1:0];
                OFS_FILT: filt <= wdata[RATE_W-1:0];
                OFS_CTRL: ctrl <= wdata;
                default:  ;
            endcase
        end
    end

    AST_RATE_NARROW: assert property (@(posedge clk) disable iff (!rst_n)
        (we && addr == OFS_FDIV) |=> (fdiv == $past(wdata[RATE_W-1:0]))); // R2
endmodule

// File: rtl/i2cs_phase_seq.sv
// Module: two-step sequencer. Each enabled data access flips the step.
// Emits a timer start for every access except a payload-step read, which
// instead completes at once. Assumes read and write never target the data
// register in the same cycle as a control write.
module i2cs_phase_seq
    import i2cs_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  enable,
    input  logic  dat_wr,
    input  logic  dat_rd,
    input  logic  step_clear,
    output step_e step,
    output logic  tmr_start,
    output logic  done_now
);
    logic acc;
    assign acc = enable && (dat_wr || dat_rd);

    // Decode the timer start versus the immediate completion.
    always_comb begin
        tmr_start = acc && (dat_wr || step == STEP_ADDR);
        done_now  = enable && dat_rd && !dat_wr && (step == STEP_DATA);
    end

    // Step register: restart wins, otherwise an enabled access toggles it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            step <= STEP_ADDR;
        end else if (step_clear) begin
            step <= STEP_ADDR;
        end else if (acc) begin
            step <= (step == STEP_ADDR) ? STEP_DATA : STEP_ADDR;
        end
    end

    AST_STEP_FLIP: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && !step_clear) |=> (step != $past(step))); // R5
    AST_DISABLED_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!enable && !step_clear) |=> $stable(step)); // R3
    AST_RESTART_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
        step_clear |=> (step == STEP_ADDR)); // R4
endmodule

// File: rtl/i2cs_done_timer.sv
// Module: completion delay counter. A start (re)loads PRE_DIV*POST_DIV and
// the expiry pulse fires on the edge that delay after the start edge.
// Assumes PRE_DIV*POST_DIV >= 2.
module i2cs_done_timer #(
    parameter int PRE_DIV  = 512,
    parameter int POST_DIV = 64
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic expire
);
    localparam int DELAY = PRE_DIV * POST_DIV;
    localparam int CW    = $clog2(DELAY + 1);

    logic          busy;
    logic [CW-1:0] cnt;

    assign expire = busy && (cnt == CW'(1)) && !start;

    // Count down while busy; a new start reloads the full delay.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy <= 1'b0;
            cnt  <= '0;
        end else if (start) begin
            busy <= 1'b1;
            cnt  <= CW'(DELAY);
        end else if (busy) begin
            cnt  <= cnt - CW'(1);
            busy <= (cnt != CW'(1));
        end
    end

    AST_TMR_ARMED: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> (busy && !expire)); // R8
    AST_TMR_ONESHOT: assert property (@(posedge clk) disable iff (!rst_n)
        expire |=> !busy); // R7
endmodule

// File: rtl/i2cs_regblk.sv
// Module: top of the I2C register model. Decodes the bus, keeps the status
// register, muxes read data and drives the interrupt level. Assumes one
// access (read or write) per cycle.
module i2cs_regblk
    import i2cs_pkg::*;
#(
    parameter int PRE_DIV  = 512,
    parameter int POST_DIV = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [REG_AW-1:0] bus_addr,
    input  logic [BYTE_W-1:0] bus_wdata,
    input  logic              bus_we,
    input  logic              bus_re,
    output logic [BYTE_W-1:0] bus_rdata,
    output logic              irq
);
    logic [BYTE_W-1:0] sadr, ctrl, sts, sts_next;
    logic [RATE_W-1:0] fdiv, filt;
    logic              step_clear, tmr_start, done_now, expire;
    logic              dat_wr, dat_rd, sts_wr;
    step_e             step;

    assign dat_wr = bus_we && (bus_addr == OFS_DATA);
    assign dat_rd = bus_re && (bus_addr == OFS_DATA);
    assign sts_wr = bus_we && (bus_addr == OFS_STAT);

    i2cs_cfg_regs u_cfg (
        .clk        (clk),
        .rst_n      (rst_n),
        .addr       (bus_addr),
        .wdata      (bus_wdata),
        .we         (bus_we),
        .sadr       (sadr),
        .fdiv       (fdiv),
        .filt       (filt),
        .ctrl       (ctrl),
        .step_clear (step_clear)
    );

    i2cs_phase_seq u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .enable     (ctrl[CTL_EN]),
        .dat_wr     (dat_wr),
        .dat_rd     (dat_rd),
        .step_clear (step_clear),
        .step       (step),
        .tmr_start  (tmr_start),
        .done_now   (done_now)
    );

    i2cs_done_timer #(
        .PRE_DIV  (PRE_DIV),
        .POST_DIV (POST_DIV)
    ) u_tmr (
        .clk    (clk),
        .rst_n  (rst_n),
        .start  (tmr_start),
        .expire (expire)
    );

    // Next status: a software write replaces, then hardware flags OR in.
    always_comb begin
        sts_next = sts;
        if (sts_wr) sts_next = bus_wdata;
        if (expire) begin
            sts_next[STS_DONE] = 1'b1;
            if (ctrl[CTL_IE]) sts_next[STS_PEND] = 1'b1;
        end
        if (done_now) sts_next[STS_DONE] = 1'b1;
    end

    // Status register.
    always_ff @(posedge clk) begin
        if (!rst_n) sts <= '0;
        else        sts <= sts_next;
    end

    // Read data mux; the data register always reads as zero.
    always_comb begin
        case (bus_addr)
            OFS_SADR: bus_rdata = sadr;
            OFS_FDIV: bus_rdata = {{(BYTE_W-RATE_W){1'b0}}, fdiv};
            OFS_FILT: bus_rdata = {{(BYTE_W-RATE_W){1'b0}}, filt};
            OFS_CTRL: bus_rdata = ctrl;
            OFS_STAT: bus_rdata = sts;
            default:  bus_rdata = '0;
        endcase
    end

    // Interrupt level output.
    assign irq = sts[STS_PEND] && ctrl[CTL_IE];

    AST_DATA_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_re && bus_addr == OFS_DATA) |-> (bus_rdata == '0)); // R11
    AST_EXPIRE_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        (expire && !sts_wr) |=> sts[STS_DONE]); // R7
    AST_QUIET_READ: assert property (@(posedge clk) disable iff (!rst_n)
        (done_now && !expire && !sts_wr) |=> (sts[STS_DONE] && sts[STS_PEND] == $past(sts[STS_PEND]))); // R6
    AST_STS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (sts_wr && !expire && !done_now) |=> (sts == $past(bus_wdata))); // R9
endmodule

// File: tb/i2cs_regblk_tb.sv
`timescale 1ns/1ps
module i2cs_regblk_tb;
    localparam int PRE = 4, POST = 2, DLY = PRE * POST;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [4:0] bus_addr = '0;
    logic [7:0] bus_wdata = '0;
    logic       bus_we = 1'b0, bus_re = 1'b0;
    logic [7:0] bus_rdata;
    logic       irq;
    int         n_chk = 0, n_fail = 0;
    logic [7:0] v;

    always #2 clk = ~clk;

    i2cs_regblk #(.PRE_DIV(PRE), .POST_DIV(POST)) u_dut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_we(bus_we), .bus_re(bus_re), .bus_rdata(bus_rdata), .irq(irq)
    );

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [4:0] a, input logic [7:0] d);
        @(negedge clk); bus_addr = a; bus_wdata = d; bus_we = 1'b1;
        @(negedge clk); bus_we = 1'b0;
    endtask

    task automatic rd(input logic [4:0] a, output logic [7:0] d);
        @(negedge clk); bus_addr = a; bus_re = 1'b1; #1 d = bus_rdata;
        @(negedge clk); bus_re = 1'b0;
    endtask

    task automatic peek(input logic [4:0] a, output logic [7:0] d);
        bus_addr = a; #1 d = bus_rdata;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic sts_is(input string tag, input logic [7:0] exp, input logic exp_irq);
        logic [7:0] s;
        peek(5'h0C, s);
        chk(tag, s, exp);
        chk({tag, " irq"}, {7'd0, irq}, {7'd0, exp_irq});
    endtask

    initial begin
        #(4 * 200000);
        n_fail++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        idle(3); rst_n = 1'b1; idle(1);
        // R1 reset values
        foreach (u_dut.bus_addr[i]) ; // no-op
        begin
            logic [4:0] offs [6] = '{5'h00, 5'h04, 5'h05, 5'h08, 5'h0C, 5'h10};
            for (int i = 0; i < 6; i++) begin
                peek(offs[i], v); chk("R1 reset value", v, 8'h00);
            end
        end
        chk("R1 irq after reset", {7'd0, irq}, 8'h00);

        // R2 sweep of the narrow fields; full-width slave address
        for (int i = 0; i < 256; i++) begin
            wr(5'h04, 8'(i)); peek(5'h04, v); chk("R2 divider", v, 8'(i) & 8'h3F);
            wr(5'h05, 8'(255 - i)); peek(5'h05, v); chk("R2 filter", v, 8'(255 - i) & 8'h3F);
        end
        wr(5'h00, 8'hA5); peek(5'h00, v); chk("R2 slave address", v, 8'hA5);

        // R9 / R10 status write and irq level
        wr(5'h08, 8'hC0);
        wr(5'h0C, 8'hFF); sts_is("R9 status write", 8'hFF, 1'b1);
        wr(5'h08, 8'h80); chk("R10 irq masked", {7'd0, irq}, 8'h00);
        wr(5'h08, 8'hC0); chk("R10 irq unmasked", {7'd0, irq}, 8'h01);
        wr(5'h0C, 8'h00); sts_is("R9 status clear", 8'h00, 1'b0);

        // R5 writes in both steps, timer latency R7
        wr(5'h10, 8'h55);
        idle(DLY - 1); sts_is("R7 before expiry", 8'h00, 1'b0);
        idle(1);       sts_is("R5 addr-step write completes", 8'h82, 1'b1);
        wr(5'h0C, 8'h00);
        wr(5'h10, 8'h3C);
        idle(DLY - 1); sts_is("R7 before expiry", 8'h00, 1'b0);
        idle(1);       sts_is("R5 data-step write completes", 8'h82, 1'b1);
        wr(5'h0C, 8'h00);

        // R6 / R11 reads in both steps
        rd(5'h10, v); chk("R11 data read", v, 8'h00);
        sts_is("R6 addr-step read not instant", 8'h00, 1'b0);
        idle(DLY - 1); sts_is("R6 before expiry", 8'h00, 1'b0);
        idle(1);       sts_is("R6 addr-step read completes", 8'h82, 1'b1);
        wr(5'h0C, 8'h00);
        rd(5'h10, v); chk("R11 data read", v, 8'h00);
        sts_is("R6 data-step read instant", 8'h80, 1'b0);
        idle(DLY + 2); sts_is("R6 no interrupt later", 8'h80, 1'b0);
        wr(5'h0C, 8'h00);

        // R7 interrupt enable off
        wr(5'h08, 8'h80);
        wr(5'h10, 8'h20);
        idle(DLY); sts_is("R7 no pending without enable", 8'h80, 1'b0);
        wr(5'h0C, 8'h00);
        wr(5'h08, 8'hC0);
        wr(5'h10, 8'h00); idle(DLY); wr(5'h0C, 8'h00);

        // R8 restart while running
        wr(5'h10, 8'h10);
        idle(3);
        wr(5'h10, 8'h11);
        idle(DLY - 1); sts_is("R8 first expiry cancelled", 8'h00, 1'b0);
        idle(1);       sts_is("R8 restarted expiry", 8'h82, 1'b1);
        wr(5'h0C, 8'h00);

        // R3 disabled accesses do nothing
        wr(5'h08, 8'h40);
        wr(5'h10, 8'h77);
        rd(5'h10, v); chk("R11 disabled read", v, 8'h00);
        idle(DLY + 2); sts_is("R3 disabled no flags", 8'h00, 1'b0);
        wr(5'h08, 8'hC0);

        // R4 restart conditions
        wr(5'h10, 8'h01); idle(DLY); wr(5'h0C, 8'h00);
        wr(5'h08, 8'h40); wr(5'h08, 8'hC0);
        rd(5'h10, v); sts_is("R4 enable rise to addr step", 8'h00, 1'b0);
        idle(DLY); wr(5'h0C, 8'h00);
        wr(5'h08, 8'hD0);
        rd(5'h10, v); sts_is("R4 bit4 change to addr step", 8'h00, 1'b0);
        idle(DLY); wr(5'h0C, 8'h00);
        wr(5'h08, 8'hD0);
        rd(5'h10, v); sts_is("R4 unchanged control keeps step", 8'h80, 1'b0);
        wr(5'h0C, 8'h00);
        wr(5'h08, 8'hC0);

        // R12 reset cancels the timer and returns to the address step
        wr(5'h10, 8'h02);
        idle(2);
        rst_n = 1'b0; idle(2); rst_n = 1'b1;
        idle(DLY + 2); sts_is("R12 timer cancelled", 8'h00, 1'b0);
        wr(5'h08, 8'hC0);
        rd(5'h10, v); sts_is("R12 address step after reset", 8'h00, 1'b0);
        idle(DLY); sts_is("R12 later expiry", 8'h82, 1'b1);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule